// File: doc/BRIEF.md
# Ethernet MAC Enable and Soft-Reset Control

This block is the control register that decides whether an Ethernet MAC may move frames. A single enable bit opens the receive and transmit paths. A self-clearing reset bit starts a fixed-length local reset of the MAC's registers. Software reaches both bits through a plain register write and read port. The block also watches a transmit engine (frame in progress, end of frame) and a bus-error detector, and drives the gating and clearing signals those neighbours need.

Turning the enable off stops reception in the next cycle. A transmit frame that is still on the wire is not cut short. Instead the transmit path is asked to finish it with a corrupted CRC, and the descriptor write-back for that frame is suppressed. A soft reset behaves differently. It aborts transfers outright with no CRC tail, holds the other MAC registers in reset for a fixed number of cycles, and then clears itself.

Top module: `mac_ctl_gate`

## Requirements
- R1: After reset, the enable is 0 and the read data is 0. `rx_enable`, `tx_enable`, `tx_bad_crc`, `tx_abort` and `regs_reset` are 0, and `dma_clear` is 1.
- R2: A write with bit 1 = 1 and bit 0 = 0 sets the enable. From the cycle after the write, `rx_enable` and `tx_enable` are 1, `dma_clear` is 0, and read bit 1 is 1.
- R3: Read bits 31:2 are always 0, whatever value was written.
- R4: A write with bit 1 = 0 and bit 0 = 0 clears the enable. From the cycle after the write, `rx_enable` is 0 and `dma_clear` is 1 (the DMA, descriptor and FIFO pointer logic is held clear).
- R5: Suppose the enable falls through a write or a bus error while `tx_busy` is 1 and `tx_eof` is 0. Then `tx_bad_crc` and `tx_wb_suppress` are 1 from the next cycle. Both stay 1 until a cycle with `tx_eof` = 1, and are 0 from the cycle after that one. If `tx_busy` is 0 when the enable falls, `tx_bad_crc` stays 0.
- R6: While `tx_bad_crc` is 1, `tx_enable` is 0, even if software sets the enable again. `rx_enable` follows the enable bit at once.
- R7: A cycle with `bus_err` = 1 leaves the enable at 0 in the next cycle, even if a write setting the enable happens in that same cycle.
- R8: A write with bit 0 = 1, made while no reset sequence is running, starts the reset sequence. For exactly RST_CYCLES cycles after the write, `regs_reset`, `tx_abort`, `tx_wb_suppress` and read bit 0 are 1. During the same cycles the enable is 0 and `tx_bad_crc` is 0, and any pending bad-CRC request is cancelled. The reset bit then reads 0 again.
- R9: Writes made during the reset sequence are ignored. This covers writes that set the enable or the reset bit: the enable is still 0 after the sequence ends.
- R10: After the sequence ends, an enable write takes effect again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Write data: bit 1 is the enable, bit 0 is the reset |
| cfg_rdata | output | 32 | Read data: bit 1 is the enable, bit 0 shows that a reset sequence is running |
| tx_busy | input | 1 | Transmit engine has a frame in progress |
| tx_eof | input | 1 | Transmit engine finishes its frame this cycle |
| bus_err | input | 1 | Bus-error condition detected |
| rx_enable | output | 1 | Receive path allowed |
| tx_enable | output | 1 | Transmit path may start frames |
| tx_bad_crc | output | 1 | Finish the current frame with a corrupted CRC |
| tx_wb_suppress | output | 1 | Do not write back the descriptor of the current frame |
| tx_abort | output | 1 | Abort the transmit path immediately |
| dma_clear | output | 1 | Synchronous clear for DMA, descriptor and FIFO pointers |
| regs_reset | output | 1 | Reset to the other MAC registers |

## Verification
All results come from a single register stage. An enable, bus-error or end-of-frame event at one rising edge is visible on the outputs just after that edge. The reset outputs stay high for the RST_CYCLES edges that follow the write. The bench drives inputs on the falling edge and samples on the next falling edge, so each check sees the state after exactly one rising edge. Inside the reset window, the bench samples at every falling edge and keeps count. It expects the reset outputs on samples 1 through RST_CYCLES and none on the sample after that.

// File: rtl/mac_ctl_gate.sv
module mac_ctl_gate #(
  parameter int REG_W      = 32,
  parameter int EN_BIT     = 1,
  parameter int RST_BIT    = 0,
  parameter int RST_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             tx_busy,
  input  logic             tx_eof,
  input  logic             bus_err,
  output logic             rx_enable,
  output logic             tx_enable,
  output logic             tx_bad_crc,
  output logic             tx_wb_suppress,
  output logic             tx_abort,
  output logic             dma_clear,
  output logic             regs_reset
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic             en_q, bad_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seq_busy, wr_ok, start, en_nxt;

  assign seq_busy = (cnt_q != '0);
  assign wr_ok    = cfg_we && !seq_busy;
  assign start    = wr_ok && cfg_wdata[RST_BIT];

  always_comb begin
    en_nxt = en_q;
    if (wr_ok)   en_nxt = cfg_wdata[EN_BIT];
    if (bus_err) en_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      bad_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      en_q  <= 1'b0;
      bad_q <= 1'b0;
      cnt_q <= CNT_LOAD;
    end else begin
      en_q <= en_nxt;
      if (seq_busy) cnt_q <= cnt_q - 1'b1;
      if (tx_eof)                            bad_q <= 1'b0;
      else if (en_q && !en_nxt && tx_busy)   bad_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata          = '0;
    cfg_rdata[EN_BIT]  = en_q;
    cfg_rdata[RST_BIT] = seq_busy;
  end

  assign rx_enable      = en_q;
  assign tx_enable      = en_q && !bad_q;
  assign tx_bad_crc     = bad_q;
  assign tx_wb_suppress = bad_q || seq_busy;
  assign tx_abort       = seq_busy;
  assign regs_reset     = seq_busy;
  assign dma_clear      = !en_q;
endmodule

module mac_ctl_gate_chk #(
  parameter int REG_W   = 32,
  parameter int RST_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             tx_eof,
  input logic             bus_err,
  input logic             rx_enable,
  input logic             tx_enable,
  input logic             tx_bad_crc,
  input logic             regs_reset
);
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:2] == '0);

  p_buserr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !rx_enable);

  p_badcrc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bad_crc && !tx_eof && !(cfg_we && cfg_wdata[RST_BIT])) |=> tx_bad_crc);

  p_badcrc_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bad_crc && tx_eof) |=> !tx_bad_crc);

  p_tx_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bad_crc |-> !tx_enable);

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |-> (!rx_enable && !tx_bad_crc));

  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    regs_reset |=> !rx_enable);
endmodule

bind mac_ctl_gate mac_ctl_gate_chk #(.REG_W(REG_W), .RST_BIT(RST_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .tx_eof(tx_eof), .bus_err(bus_err),
  .rx_enable(rx_enable), .tx_enable(tx_enable), .tx_bad_crc(tx_bad_crc),
  .regs_reset(regs_reset)
);

// File: tb/test_mac_ctl_gate.sv
module test_mac_ctl_gate;
  localparam int RSTC = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic tx_busy = 1'b0, tx_eof = 1'b0, bus_err = 1'b0;
  logic rx_enable, tx_enable, tx_bad_crc, tx_wb_suppress, tx_abort, dma_clear, regs_reset;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_ctl_gate #(.RST_CYCLES(RSTC)) i_mac_ctl_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_busy(tx_busy), .tx_eof(tx_eof), .bus_err(bus_err),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .tx_bad_crc(tx_bad_crc),
    .tx_wb_suppress(tx_wb_suppress), .tx_abort(tx_abort), .dma_clear(dma_clear),
    .regs_reset(regs_reset)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] d);
    cfg_we = we; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", cfg_rdata, 0);
    chk("R1 rx_enable", rx_enable, 0);
    chk("R1 tx_enable", tx_enable, 0);
    chk("R1 dma_clear", dma_clear, 1);
    chk("R1 bad_crc", tx_bad_crc, 0);
    chk("R1 abort/regs_reset", {tx_abort, regs_reset}, 0);

    // R2 R3 R4 sweep: bit0 kept 0, other bits varied
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d;
      d = (32'(i) * 32'h9E37_79B6) ^ (32'(i) << 26);
      d[0] = 1'b0;
      step(1'b1, d);
      chk("R3 rdata upper zero", cfg_rdata, {30'b0, d[1], 1'b0});
      chk(d[1] ? "R2 rx_enable" : "R4 rx_enable", rx_enable, d[1]);
      chk(d[1] ? "R2 tx_enable" : "R4 tx_enable", tx_enable, d[1]);
      chk(d[1] ? "R2 dma_clear" : "R4 dma_clear", dma_clear, !d[1]);
      chk("R5 no bad_crc when idle", tx_bad_crc, 0);
    end

    // R5 R6 disable mid-frame
    step(1'b1, 32'h2);
    tx_busy = 1'b1;
    step(1'b1, 32'h0);
    chk("R5 bad_crc set", tx_bad_crc, 1);
    chk("R5 wb_suppress", tx_wb_suppress, 1);
    chk("R4 rx stop", rx_enable, 0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 0);
      chk("R5 bad_crc held", tx_bad_crc, 1);
    end
    step(1'b1, 32'h2);
    chk("R6 rx_enable re-set", rx_enable, 1);
    chk("R6 tx_enable gated", tx_enable, 0);
    tx_eof = 1'b1;
    step(1'b0, 0);
    tx_eof = 1'b0; tx_busy = 1'b0;
    chk("R5 bad_crc cleared by eof", tx_bad_crc, 0);
    chk("R5 wb_suppress cleared", tx_wb_suppress, 0);
    chk("R6 tx_enable restored", tx_enable, 1);

    // R7 bus error wins over simultaneous enable write
    tx_busy = 1'b1;
    bus_err = 1'b1;
    step(1'b1, 32'h2);
    bus_err = 1'b0;
    chk("R7 enable cleared", rx_enable, 0);
    chk("R7 dma_clear", dma_clear, 1);
    chk("R5 bad_crc via bus error", tx_bad_crc, 1);
    tx_eof = 1'b1;
    step(1'b0, 0);
    tx_eof = 1'b0;
    chk("R5 eof clears", tx_bad_crc, 0);

    // R8 R9 soft reset mid-frame
    step(1'b1, 32'h2);
    chk("R2 enable before reset", rx_enable, 1);
    cfg_we = 1'b1; cfg_wdata = 32'h3;
    @(negedge clk);
    for (int k = 1; k <= RSTC + 1; k++) begin
      logic exp_b;
      exp_b = (k <= RSTC);
      chk("R8 regs_reset window", regs_reset, exp_b);
      chk("R8 tx_abort window", tx_abort, exp_b);
      chk("R8 wb_suppress window", tx_wb_suppress, exp_b);
      chk("R8 rdata reset bit", cfg_rdata, {31'b0, exp_b});
      chk("R8 no bad_crc", tx_bad_crc, 0);
      chk("R9 enable stays off", rx_enable, 0);
      cfg_we = (k <= RSTC);
      cfg_wdata = (k % 2 == 1) ? 32'h2 : 32'h3;
      @(negedge clk);
    end
    cfg_we = 1'b0; cfg_wdata = '0; tx_busy = 1'b0;
    chk("R9 no restart", regs_reset, 0);
    chk("R9 enable still off", rx_enable, 0);

    // R10 writes effective again
    step(1'b1, 32'h2);
    chk("R10 enable after reset", cfg_rdata, 32'h2);
    chk("R10 tx_enable", tx_enable, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule